// File: doc/BRIEF.md
# Write-Snooping Automatic Update Engine

The engine sits beside a local memory bus and watches every write that crosses it. Each write's address is split into a physical page number and a word offset. The page number selects an entry in a per-page outgoing map, and each entry says whether that page is bound to a remote receive buffer and, if so, which node and which remote page it reaches. A write to a bound page becomes network traffic with no send command: the store itself is the trigger. The offset within the page is carried unchanged, because local and remote buffers are both page-aligned.

Writes to sequential word offsets within one page are merged into a single packet. The open packet is closed when a write breaks the sequence, when the page changes, when the payload limit is reached, or when a programmable number of cycles passes with no bound write. Closed packets are queued in a small packet FIFO. They leave as a word stream: one header word, then the payload words. When the FIFO has no room for a packet that a write would close, the engine holds that write on the bus with a wait signal and never drops it. Packets from this engine carry no ordering relation to block transfers started by other means.

Top module: `auto_update_engine`

## Requirements
- R1: After reset, `pkt_valid_o` and `bus_wait_o` are low and every page is unbound, so no write produces a packet until a page is bound.
- R2: A single write to a bound page produces one packet. Its header word has the word count in bits [2:0], the starting offset in bits [8:3], the remote page in bits [16:9], the destination node in bits [20:17], and zero above. The data word follows the header.
- R3: A snooped read, or a write to an unbound page, produces no packet and never raises `bus_wait_o`.
- R4: Writes to sequential offsets (each one more than the last) in the same page are merged into one packet of at most MAX_WORDS (4) words. The write that brings the count to MAX_WORDS closes the packet at once.
- R5: A bound write whose offset is not the next sequential one, or whose page differs from the open packet's page, closes the open packet. The new write starts a new packet. Offset 63 followed by offset 0 of the next page is never merged.
- R6: If a packet is open and no bound write is accepted for `idle_limit_i` consecutive cycles, the packet is queued at the end of the last of those cycles. Its header appears on the output in the following cycle.
- R7: The FIFO holds FIFO_DEPTH (2) packets. If a bound write would close a packet while the FIFO is full, `bus_wait_o` stays high until space frees up. The held write is then taken and no data is lost.
- R8: The output stream sends the header and then each payload word in write order. `pkt_last_o` is high only on the final payload word. Data is held stable while `pkt_ready_i` is low.
- R9: A map update takes effect for writes from the next cycle. A write in the same cycle uses the previous entry. An open packet keeps the destination it captured when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus transfer present |
| bus_write_i | input | 1 | Transfer is a write (0 = read) |
| bus_addr_i | input | 10 | Word address: page in [9:6], offset in [5:0] |
| bus_data_i | input | 32 | Write data |
| bus_wait_o | output | 1 | Stall the current write |
| map_we_i | input | 1 | Update one map entry |
| map_page_i | input | 4 | Local page to update |
| map_bound_i | input | 1 | Entry binds the page when high |
| map_node_i | input | 4 | Destination node |
| map_rpage_i | input | 8 | Destination page |
| idle_limit_i | input | 8 | Idle cycles before an open packet closes |
| pkt_valid_o | output | 1 | Output word valid |
| pkt_data_o | output | 32 | Header or payload word |
| pkt_last_o | output | 1 | Last word of packet |
| pkt_ready_i | input | 1 | Downstream accepts word |

## Verification
The bench builds the engine with its default parameters: 16 pages of 64 words, a four-word payload limit, and a two-packet FIFO. The shallow FIFO and the short payload mean that FIFO-full stalls and immediate closes at the payload limit can be reached in a few writes. Holding `pkt_ready_i` low makes the stall appear after three broken-sequence writes. The idle limit is a port, so the bench checks two timeout values in one run, and page 3 sits next to page 2 so that the page-crossing case can be checked.

// File: rtl/aue_pkg.sv
package aue_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_APPEND,
    ACT_START,
    ACT_CLOSE
  } act_e;
endpackage

// File: rtl/aue_page_table.sv
module aue_page_table #(
  parameter int PPN_W   = 4,
  parameter int NODE_W  = 4,
  parameter int RPAGE_W = 8,
  localparam int NPAGES = 1 << PPN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PPN_W-1:0]   wr_page_i,
  input  logic               wr_bound_i,
  input  logic [NODE_W-1:0]  wr_node_i,
  input  logic [RPAGE_W-1:0] wr_rpage_i,
  input  logic [PPN_W-1:0]   rd_page_i,
  output logic               rd_bound_o,
  output logic [NODE_W-1:0]  rd_node_o,
  output logic [RPAGE_W-1:0] rd_rpage_o
);
  logic [NPAGES-1:0] bound_vec;
  logic [NODE_W-1:0]  node_arr  [NPAGES];
  logic [RPAGE_W-1:0] rpage_arr [NPAGES];

  for (genvar g = 0; g < NPAGES; g++) begin : g_ent
    logic               b_q;
    logic [NODE_W-1:0]  n_q;
    logic [RPAGE_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_q <= 1'b0;
        n_q <= '0;
        r_q <= '0;
      end else if (we_i && (wr_page_i == PPN_W'(g))) begin
        b_q <= wr_bound_i;
        n_q <= wr_node_i;
        r_q <= wr_rpage_i;
      end
    end
    assign bound_vec[g] = b_q;
    assign node_arr[g]  = n_q;
    assign rpage_arr[g] = r_q;
  end

  assign rd_bound_o = bound_vec[rd_page_i];
  assign rd_node_o  = node_arr[rd_page_i];
  assign rd_rpage_o = rpage_arr[rd_page_i];
endmodule

// File: rtl/aue_combiner.sv
module aue_combiner
  import aue_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PPN_W     = 4,
  parameter int OFF_W     = 6,
  parameter int NODE_W    = 4,
  parameter int RPAGE_W   = 8,
  parameter int MAX_WORDS = 4,
  parameter int IDLE_W    = 8,
  localparam int ADDR_W   = PPN_W + OFF_W,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int PKT_W    = (MAX_WORDS + 1) * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               hit_i,
  input  logic [NODE_W-1:0]  node_i,
  input  logic [RPAGE_W-1:0] rpage_i,
  input  logic [IDLE_W-1:0]  idle_limit_i,
  input  logic               full_i,
  output logic               stall_o,
  output logic               push_o,
  output logic [PKT_W-1:0]   pkt_o
);
  localparam int F_OFF  = CNT_W;
  localparam int F_RPG  = CNT_W + OFF_W;
  localparam int F_NODE = CNT_W + OFF_W + RPAGE_W;

  logic               open_q;
  logic [PPN_W-1:0]   ppn_q;
  logic [OFF_W-1:0]   off_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NODE_W-1:0]  node_q;
  logic [RPAGE_W-1:0] rpage_q;
  logic [DATA_W-1:0]  words_q [MAX_WORDS];
  logic [IDLE_W-1:0]  idle_q;

  logic [PPN_W-1:0] ppn_in;
  logic [OFF_W-1:0] off_in;
  logic [OFF_W:0]   next_off;
  logic bound_wr, consec, app, ends_full, need_push, idle_exp;
  act_e act;
  logic [DATA_W-1:0] hdr;

  assign ppn_in    = addr_i[ADDR_W-1:OFF_W];
  assign off_in    = addr_i[OFF_W-1:0];
  assign bound_wr  = wr_i & hit_i;
  // wide sum so offset 63 + 1 never wraps onto offset 0
  assign next_off  = {1'b0, off_q} + (OFF_W+1)'(cnt_q);
  assign consec    = open_q && (ppn_in == ppn_q) && ({1'b0, off_in} == next_off);
  assign app       = bound_wr & consec;
  assign ends_full = (cnt_q == CNT_W'(MAX_WORDS - 1));
  assign need_push = bound_wr & open_q & (~consec | ends_full);
  assign stall_o   = need_push & full_i;
  assign idle_exp  = open_q & ~bound_wr &
                     (((IDLE_W+1)'(idle_q) + (IDLE_W+1)'(1)) >= (IDLE_W+1)'(idle_limit_i));
  assign push_o    = ~full_i & (need_push | idle_exp);

  always_comb begin
    if (bound_wr && !stall_o) act = consec ? ACT_APPEND : ACT_START;
    else if (idle_exp && !full_i) act = ACT_CLOSE;
    else act = ACT_HOLD;
  end

  always_comb begin
    hdr = '0;
    hdr[CNT_W-1:0]          = app ? cnt_q + CNT_W'(1) : cnt_q;
    hdr[F_OFF +: OFF_W]     = off_q;
    hdr[F_RPG +: RPAGE_W]   = rpage_q;
    hdr[F_NODE +: NODE_W]   = node_q;
    pkt_o = '0;
    pkt_o[DATA_W-1:0] = hdr;
    for (int i = 0; i < MAX_WORDS; i++) begin
      pkt_o[(i+1)*DATA_W +: DATA_W] = (app && (CNT_W'(i) == cnt_q)) ? data_i : words_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      ppn_q   <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      node_q  <= '0;
      rpage_q <= '0;
      idle_q  <= '0;
      for (int i = 0; i < MAX_WORDS; i++) words_q[i] <= '0;
    end else begin
      unique case (act)
        ACT_APPEND: begin
          idle_q <= '0;
          if (ends_full) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            for (int i = 0; i < MAX_WORDS; i++)
              if (CNT_W'(i) == cnt_q) words_q[i] <= data_i;
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ACT_START: begin
          open_q     <= 1'b1;
          ppn_q      <= ppn_in;
          off_q      <= off_in;
          node_q     <= node_i;
          rpage_q    <= rpage_i;
          cnt_q      <= CNT_W'(1);
          words_q[0] <= data_i;
          idle_q     <= '0;
        end
        ACT_CLOSE: begin
          open_q <= 1'b0;
          cnt_q  <= '0;
        end
        default: begin
          if (open_q && !bound_wr && !idle_exp) idle_q <= idle_q + IDLE_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/aue_pkt_fifo.sv
module aue_pkt_fifo #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3,
  parameter int PKT_W  = 160,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PKT_W-1:0]  pkt_i,
  output logic              full_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  logic [PKT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [CNT_W-1:0] beat_q;
  logic [PKT_W-1:0] head;
  logic do_push, adv, pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign head        = mem_q[rd_ptr_q];
  assign full_o      = (lvl_q == LVL_W'(DEPTH));
  assign out_valid_o = (lvl_q != '0);
  assign out_data_o  = head[int'(beat_q)*DATA_W +: DATA_W];
  assign out_last_o  = (beat_q == head[CNT_W-1:0]);
  assign do_push     = push_i & ~full_o;
  assign adv         = out_valid_o & out_ready_i;
  assign pop         = adv & out_last_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= pkt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
      beat_q   <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop) begin
        rd_ptr_q <= bump(rd_ptr_q);
        beat_q   <= '0;
      end else if (adv) begin
        beat_q <= beat_q + CNT_W'(1);
      end
      lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(pop);
    end
  end
endmodule

// File: rtl/auto_update_engine.sv
module auto_update_engine #(
  parameter int DATA_W     = 32,
  parameter int PPN_W      = 4,
  parameter int OFF_W      = 6,
  parameter int NODE_W     = 4,
  parameter int RPAGE_W    = 8,
  parameter int MAX_WORDS  = 4,
  parameter int FIFO_DEPTH = 2,
  parameter int IDLE_W     = 8,
  localparam int ADDR_W    = PPN_W + OFF_W,
  localparam int CNT_W     = $clog2(MAX_WORDS + 1),
  localparam int PKT_W     = (MAX_WORDS + 1) * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  output logic               bus_wait_o,
  input  logic               map_we_i,
  input  logic [PPN_W-1:0]   map_page_i,
  input  logic               map_bound_i,
  input  logic [NODE_W-1:0]  map_node_i,
  input  logic [RPAGE_W-1:0] map_rpage_i,
  input  logic [IDLE_W-1:0]  idle_limit_i,
  output logic               pkt_valid_o,
  output logic [DATA_W-1:0]  pkt_data_o,
  output logic               pkt_last_o,
  input  logic               pkt_ready_i
);
  logic               hit;
  logic [NODE_W-1:0]  hit_node;
  logic [RPAGE_W-1:0] hit_rpage;
  logic               fifo_full, push;
  logic [PKT_W-1:0]   pkt;

  aue_page_table #(
    .PPN_W(PPN_W), .NODE_W(NODE_W), .RPAGE_W(RPAGE_W)
  ) i_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(map_we_i), .wr_page_i(map_page_i), .wr_bound_i(map_bound_i),
    .wr_node_i(map_node_i), .wr_rpage_i(map_rpage_i),
    .rd_page_i(bus_addr_i[ADDR_W-1:OFF_W]),
    .rd_bound_o(hit), .rd_node_o(hit_node), .rd_rpage_o(hit_rpage)
  );

  aue_combiner #(
    .DATA_W(DATA_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .NODE_W(NODE_W),
    .RPAGE_W(RPAGE_W), .MAX_WORDS(MAX_WORDS), .IDLE_W(IDLE_W)
  ) i_comb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(bus_valid_i & bus_write_i), .addr_i(bus_addr_i), .data_i(bus_data_i),
    .hit_i(hit), .node_i(hit_node), .rpage_i(hit_rpage),
    .idle_limit_i(idle_limit_i), .full_i(fifo_full),
    .stall_o(bus_wait_o), .push_o(push), .pkt_o(pkt)
  );

  aue_pkt_fifo #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PKT_W(PKT_W), .DEPTH(FIFO_DEPTH)
  ) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .pkt_i(pkt), .full_o(fifo_full),
    .out_valid_o(pkt_valid_o), .out_data_o(pkt_data_o),
    .out_last_o(pkt_last_o), .out_ready_i(pkt_ready_i)
  );
endmodule

module aue_checker #(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 4,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic              bus_wait_o,
  input logic              pkt_valid_o,
  input logic [DATA_W-1:0] pkt_data_o,
  input logic              pkt_last_o,
  input logic              pkt_ready_i
);
  logic             in_pkt_q;
  logic [CNT_W-1:0] beat_q, hdr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q  <= 1'b0;
      beat_q    <= '0;
      hdr_cnt_q <= '0;
    end else if (pkt_valid_o && pkt_ready_i) begin
      if (!in_pkt_q) begin
        in_pkt_q  <= 1'b1;
        hdr_cnt_q <= pkt_data_o[CNT_W-1:0];
        beat_q    <= CNT_W'(1);
      end else begin
        beat_q <= beat_q + CNT_W'(1);
        if (pkt_last_o) in_pkt_q <= 1'b0;
      end
    end
  end

  // R7
  wait_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wait_o |-> (bus_valid_i && bus_write_i));

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_last_o)));

  // R4
  hdr_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !in_pkt_q) |->
      (pkt_data_o[CNT_W-1:0] != '0 && pkt_data_o[CNT_W-1:0] <= CNT_W'(MAX_WORDS) && !pkt_last_o));

  // R8
  last_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && in_pkt_q) |-> (pkt_last_o == (beat_q == hdr_cnt_q)));
endmodule

bind auto_update_engine aue_checker #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) i_aue_chk (.*);

// File: tb/test_auto_update_engine.sv
module test_auto_update_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW  = 4;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic bus_wait;
  logic map_we = 0, map_bound = 0;
  logic [3:0] map_page = '0, map_node = '0;
  logic [7:0] map_rpage = '0, idle_limit = 8'd3;
  logic pkt_valid, pkt_last, pkt_ready = 1'b1;
  logic [31:0] pkt_data;

  auto_update_engine i_auto_update_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .bus_wait_o(bus_wait),
    .map_we_i(map_we), .map_page_i(map_page), .map_bound_i(map_bound),
    .map_node_i(map_node), .map_rpage_i(map_rpage), .idle_limit_i(idle_limit),
    .pkt_valid_o(pkt_valid), .pkt_data_o(pkt_data), .pkt_last_o(pkt_last),
    .pkt_ready_i(pkt_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_tv [16];
  int m_tn [16], m_tr [16];
  bit m_open = 0;
  int m_ppn, m_off, m_cnt, m_node, m_rp, m_idle;
  logic [31:0] m_words [MAXW];
  logic [(MAXW+1)*32-1:0] mq [$];
  int m_beat = 0;

  // observation
  bit last_wait, last_valid, obs_in = 0;
  logic [31:0] last_data, obs_hdr, obs_pay0;
  int obs_pkts = 0, obs_idx = 0;

  function automatic logic [31:0] hdr_of(int node, int rp, int off, int cnt);
    return {11'b0, node[3:0], rp[7:0], off[5:0], cnt[2:0]};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit commit);
    int ppn_in, off_in, pc;
    bit bw, consec, needp, full, idle_exp, pushp, acc, e_valid, e_last;
    logic [31:0] e_data;
    logic [(MAXW+1)*32-1:0] pk;
    ppn_in = int'(bus_addr[9:6]);
    off_in = int'(bus_addr[5:0]);
    bw = bus_valid && bus_write && m_tv[ppn_in];
    consec = m_open && ppn_in == m_ppn && off_in == m_off + m_cnt;
    needp = bw && m_open && (!consec || m_cnt == MAXW - 1);
    full = (mq.size() == DEPTH);
    idle_exp = m_open && !bw && (m_idle + 1 >= int'(idle_limit));
    pushp = !full && (needp || idle_exp);
    acc = bw && !(needp && full);
    pc = (bw && consec) ? m_cnt + 1 : m_cnt;
    pk = '0;
    pk[31:0] = hdr_of(m_node, m_rp, m_off, pc);
    for (int i = 0; i < MAXW; i++)
      pk[(i+1)*32 +: 32] = (bw && consec && i == m_cnt) ? bus_data : m_words[i];
    e_valid = mq.size() > 0;
    e_data = e_valid ? mq[0][m_beat*32 +: 32] : '0;
    e_last = e_valid && (m_beat == int'(mq[0][2:0]));
    if (!commit) begin
      chk(cur_req, "bus_wait", bus_wait, needp && full);
      chk(cur_req, "pkt_valid", pkt_valid, e_valid);
      if (e_valid) begin
        chk(cur_req, "pkt_data", pkt_data, e_data);
        chk(cur_req, "pkt_last", pkt_last, e_last);
      end
      last_wait = bus_wait; last_valid = pkt_valid; last_data = pkt_data;
      if (pkt_valid && pkt_ready) begin
        if (!obs_in) begin obs_hdr = pkt_data; obs_in = 1; obs_idx = 1; end
        else begin
          if (obs_idx == 1) obs_pay0 = pkt_data;
          obs_idx++;
          if (pkt_last) begin obs_in = 0; obs_pkts++; end
        end
      end
    end else begin
      if (e_valid && pkt_ready) begin
        if (e_last) begin void'(mq.pop_front()); m_beat = 0; end
        else m_beat++;
      end
      if (pushp) mq.push_back(pk);
      if (acc) begin
        m_idle = 0;
        if (consec) begin
          if (m_cnt == MAXW - 1) begin m_open = 0; m_cnt = 0; end
          else begin m_words[m_cnt] = bus_data; m_cnt++; end
        end else begin
          m_open = 1; m_ppn = ppn_in; m_off = off_in; m_cnt = 1;
          m_node = m_tn[ppn_in]; m_rp = m_tr[ppn_in]; m_words[0] = bus_data;
        end
      end else if (pushp) begin
        m_open = 0; m_cnt = 0;
      end else if (m_open && !bw && !idle_exp) begin
        m_idle++;
      end
      if (map_we) begin
        m_tv[map_page] = map_bound; m_tn[map_page] = int'(map_node); m_tr[map_page] = int'(map_rpage);
      end
    end
  endtask

  task automatic tick();
    @(negedge clk); model_step(1'b0);
    @(posedge clk); model_step(1'b1);
    #1;
  endtask

  task automatic bus_wr(int page, int off, logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = {page[3:0], off[5:0]}; bus_data = d;
    forever begin tick(); if (!last_wait) break; end
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic map_set(int page, bit b, int node, int rp);
    map_we = 1; map_page = page[3:0]; map_bound = b; map_node = node[3:0]; map_rpage = rp[7:0];
    tick();
    map_we = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (mq.size() == 0 && !m_open) break;
      tick();
    end
    repeat (2) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base, n;
    for (int i = 0; i < 16; i++) begin m_tv[i] = 0; m_tn[i] = 0; m_tr[i] = 0; end
    for (int i = 0; i < MAXW; i++) m_words[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    cur_req = "R1";
    tick();
    chk("R1", "pkt_valid after reset", last_valid, 0);
    chk("R1", "bus_wait after reset", last_wait, 0);
    base = obs_pkts;
    bus_wr(3, 5, 32'h1111_0000);
    drain();
    chk("R1", "packets from unbound reset page", obs_pkts - base, 0);

    // R3
    cur_req = "R3";
    map_set(2, 1, 5, 8'h21);
    base = obs_pkts;
    bus_valid = 1; bus_write = 0; bus_addr = {4'd2, 6'd1};
    repeat (4) tick();
    bus_valid = 0;
    bus_wr(7, 0, 32'hDEAD_0007);
    drain();
    chk("R3", "packets from reads and unbound writes", obs_pkts - base, 0);

    // R2
    cur_req = "R2";
    base = obs_pkts;
    bus_wr(2, 10, 32'hA5A5_0010);
    drain();
    chk("R2", "single write packets", obs_pkts - base, 1);
    chk("R2", "single write header", obs_hdr, hdr_of(5, 8'h21, 10, 1));
    chk("R2", "single write payload", obs_pay0, 32'hA5A5_0010);

    // R4
    cur_req = "R4";
    base = obs_pkts;
    for (int i = 0; i < 6; i++) bus_wr(2, i, 32'hB000_0000 + i);
    drain();
    chk("R4", "merged packet count", obs_pkts - base, 2);
    chk("R4", "tail packet header", obs_hdr, hdr_of(5, 8'h21, 4, 2));
    chk("R4", "tail packet first word", obs_pay0, 32'hB000_0004);

    // R5
    cur_req = "R5";
    base = obs_pkts;
    bus_wr(2, 20, 32'hC000_0020);
    bus_wr(2, 22, 32'hC000_0022);
    drain();
    chk("R5", "gap splits packets", obs_pkts - base, 2);
    chk("R5", "gap second header", obs_hdr, hdr_of(5, 8'h21, 22, 1));
    map_set(3, 1, 6, 8'h40);
    base = obs_pkts;
    bus_wr(2, 63, 32'hC000_003F);
    bus_wr(3, 0, 32'hC000_0300);
    drain();
    chk("R5", "page change splits packets", obs_pkts - base, 2);
    chk("R5", "page change second header", obs_hdr, hdr_of(6, 8'h40, 0, 1));

    // R6
    cur_req = "R6";
    idle_limit = 8'd6;
    bus_wr(2, 12, 32'hD000_0012);
    n = 0;
    do begin tick(); n++; end while (!last_valid && n < 50);
    chk("R6", "ticks until header visible", n, 7);
    drain();
    idle_limit = 8'd3;

    // R7 and R8
    cur_req = "R7";
    pkt_ready = 0;
    base = obs_pkts;
    bus_wr(2, 30, 32'hE000_0030);
    bus_wr(2, 40, 32'hE000_0040);
    bus_wr(2, 50, 32'hE000_0050);
    bus_valid = 1; bus_write = 1; bus_addr = {4'd2, 6'd60}; bus_data = 32'hE000_0060;
    tick();
    chk("R7", "wait with full fifo", last_wait, 1);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] held;
      held = last_data;
      tick();
      chk("R7", "wait held", last_wait, 1);
      chk("R8", "data held while not ready", last_data, held);
      chk("R8", "valid held while not ready", last_valid, 1);
    end
    pkt_ready = 1;
    n = 0;
    do begin tick(); n++; end while (last_wait && n < 50);
    bus_valid = 0; bus_write = 0;
    drain();
    chk("R7", "no packet lost under stall", obs_pkts - base, 4);
    chk("R8", "last packet payload", obs_pay0, 32'hE000_0060);

    // R9
    cur_req = "R9";
    base = obs_pkts;
    bus_wr(2, 0, 32'hF000_0000);
    map_we = 1; map_page = 4'd2; map_bound = 1; map_node = 4'd9; map_rpage = 8'h33;
    bus_valid = 1; bus_write = 1; bus_addr = {4'd2, 6'd1}; bus_data = 32'hF000_0001;
    tick();
    map_we = 0; bus_valid = 0; bus_write = 0;
    m_tv[2] = m_tv[2];
    drain();
    chk("R9", "open packet keeps destination", obs_hdr, hdr_of(5, 8'h21, 0, 2));
    bus_wr(2, 8, 32'hF000_0008);
    drain();
    chk("R9", "new mapping used after update", obs_hdr, hdr_of(9, 8'h33, 8, 1));
    map_we = 1; map_page = 4'd2; map_bound = 0; map_node = 4'd0; map_rpage = 8'h00;
    bus_valid = 1; bus_write = 1; bus_addr = {4'd2, 6'd9}; bus_data = 32'hF000_0009;
    tick();
    map_we = 0; bus_valid = 0; bus_write = 0;
    drain();
    chk("R9", "same cycle write uses old entry", obs_hdr, hdr_of(9, 8'h33, 9, 1));
    bus_wr(2, 10, 32'hF000_000A);
    drain();
    chk("R9", "unbound page after update", obs_pkts - base, 3);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule